// File: doc/BRIEF.md
# Two-Wire Radio Transmitter Command Sequencer

This block sits on the host side of a low-power radio transmitter that is controlled over a two-wire serial link. The link has a clock line and a data line. The block sends fixed command sequences over that link so that the transmitter's link logic and its power state stay consistent. Three commands are used: a link reset, a soft reset and a link-off command. Their bit patterns and lengths are parameters. Bits are shifted out most significant bit first, and the receiver captures each bit on the falling edge of the link clock.

Once reset is released, the block runs a boot sequence: a link reset followed by a soft reset, which leaves the transmitter asleep. The host then pulses `start_i`. The block answers with the pre-transmission sequence: a link reset followed by link-off. When `busy_o` drops, the host runs its transmission. It then pulses `tx_done_i`, and the block sends the post-transmission sequence: a link reset followed by a soft reset. A start request that arrives while the block is busy is kept until the block is free. A done pulse that arrives while the pre-transmission sequence is still running is also kept.

The sequencer has eight states:

| State | Role |
|---|---|
| BOOT_RST | Link reset after power-up. |
| BOOT_SOFT | Soft reset after power-up. |
| IDLE | Quiet; waits for a start request. |
| PRE_RST | Link reset before a transmission. |
| PRE_OFF | Link-off before a transmission. |
| TX_WAIT | Quiet; waits for the done pulse. |
| POST_RST | Link reset after a transmission. |
| POST_SOFT | Soft reset after a transmission. |

Its transitions are:

- BOOT_RST→BOOT_SOFT, PRE_RST→PRE_OFF, PRE_OFF→TX_WAIT, POST_RST→POST_SOFT, BOOT_SOFT→IDLE and POST_SOFT→IDLE are each taken when the current command finishes.
- IDLE→PRE_RST is taken on a new or held start request.
- TX_WAIT→POST_RST is taken on a new or held done pulse.

Each command runs through the shifter's own states:

| Shifter state | Role |
|---|---|
| SH_IDLE | Link at rest. |
| SH_LOW | Clock-low half period; the data bit is set here. |
| SH_HIGH | Clock-high half period. |
| SH_TAIL | Release of the data line after the last bit. |

Top module: `tx_cmd_sequencer`

## Requirements
- R1: While `rst_n` is low, `tw_clk_o` and `tw_data_o` are 0 and `busy_o` is 1. After release, the block sends a link reset and then a soft reset (default patterns 8'h8D and 8'h5B, 8 bits each).
- R2: A start request produces a link reset followed by link-off (default 8'h37, 8 bits), in that order.
- R3: A done pulse after the pre-transmission sequence produces a link reset followed by a soft reset, in that order.
- R4: Every clock-high phase lasts exactly `HALF_DIV` system clocks, and every clock-low phase lasts at least `HALF_DIV`. Elaboration rejects settings that give a phase under 500 ns or a link clock under 10 kHz.
- R5: Bits are sent MSB first. The data line never changes while the link clock is high, or in the cycle it falls. It changes at least `HOLD_CYC` system clocks after a falling edge, and at least `HALF_DIV` clocks before the next falling edge.
- R6: The first falling edge of each sequence comes between 20 ns and 15 µs after `busy_o` rises.
- R7: Within 15 µs of the last rising edge of a sequence, the data line has returned to 0. Both lines rest at 0 between commands.
- R8: `busy_o` is high from the start of a sequence's first command until its last command releases the data line. It is low in IDLE and TX_WAIT, and the link is quiet in those states.
- R9: A start request seen while busy or in TX_WAIT is held. It launches the pre-transmission sequence as soon as the block returns to IDLE.
- R10: A done pulse seen during the pre-transmission sequence is held, and the post-transmission sequence follows at once. A done pulse seen in IDLE is dropped and has no later effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to prepare a transmission |
| tx_done_i | input | 1 | One-cycle pulse marking the end of a transmission |
| tw_clk_o | output | 1 | Link clock, idle low |
| tw_data_o | output | 1 | Link data, captured by the receiver on the clock falling edge |
| busy_o | output | 1 | High while a command sequence is on the link |

## Verification
The assertions assume that `start_i` and `tx_done_i` are synchronous to `clk`. They also assume the parameters respect the elaboration checks, so that `HOLD_CYC` lies inside one half period. The stimulus drives the request pulses one system clock wide, on the falling system-clock edge. Each done pulse is issued either inside the pre-transmission sequence, inside TX_WAIT, or deliberately in IDLE. The bench never forces anything while reset is asserted, apart from the reset-state observation.

// File: rtl/twseq_pkg.sv
package twseq_pkg;

    typedef enum logic [2:0] {
        SQ_BOOT_RST,
        SQ_BOOT_SOFT,
        SQ_IDLE,
        SQ_PRE_RST,
        SQ_PRE_OFF,
        SQ_TX_WAIT,
        SQ_POST_RST,
        SQ_POST_SOFT
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_TAIL
    } sh_state_t;

    typedef enum logic [1:0] {
        CMD_LINK_RST,
        CMD_SOFT_RST,
        CMD_LINK_OFF
    } cmd_t;

endpackage

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter
    import twseq_pkg::*;
#(
    parameter int HALF_DIV = 125,
    parameter int HOLD_CYC = 50,
    parameter int MAX_LEN  = 16,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int CNT_W   = $clog2(HALF_DIV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [MAX_LEN-1:0] pat,
    input  logic [LEN_W-1:0]   len,
    output logic               sclk,
    output logic               sdata,
    output logic               sh_idle,
    output logic               sh_done
);

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_DIV);
    localparam logic [LEN_W-1:0] MAXL_C = LEN_W'(MAX_LEN);

    sh_state_t          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [MAX_LEN-1:0] shreg;
    logic [LEN_W-1:0]   bits_left;
    logic               clk_q, data_q;
    logic               phase_end, hold_pt;

    assign phase_end = (cnt == LAST_C);
    assign hold_pt   = (cnt == HOLD_C);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE: if (go)        nxt = SH_LOW;
            SH_LOW:  if (phase_end) nxt = SH_HIGH;
            SH_HIGH: if (phase_end) nxt = (bits_left == LEN_W'(1)) ? SH_TAIL : SH_LOW;
            SH_TAIL: if (hold_pt)   nxt = SH_IDLE;
            default:                nxt = SH_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            bits_left <= '0;
            clk_q     <= 1'b0;
            data_q    <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    cnt <= '0;
                    if (go) begin
                        shreg     <= pat << (MAXL_C - len);
                        bits_left <= len;
                    end
                end
                SH_LOW: begin
                    cnt <= phase_end ? '0 : cnt + CNT_W'(1);
                    if (hold_pt)   data_q <= shreg[MAX_LEN-1];
                    if (phase_end) clk_q  <= 1'b1;
                end
                SH_HIGH: begin
                    cnt <= phase_end ? '0 : cnt + CNT_W'(1);
                    if (phase_end) begin
                        clk_q     <= 1'b0;
                        shreg     <= shreg << 1;
                        bits_left <= bits_left - LEN_W'(1);
                    end
                end
                SH_TAIL: begin
                    cnt <= cnt + CNT_W'(1);
                    if (hold_pt) data_q <= 1'b0;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign sclk    = clk_q;
    assign sdata   = data_q;
    assign sh_idle = (state == SH_IDLE);
    assign sh_done = (state == SH_TAIL) && hold_pt;

    // phase-length observers for the checks below
    logic [CNT_W-1:0] hi_run, lo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= HALF_C;
        end else begin
            hi_run <= clk_q ? hi_run + CNT_W'(1) : '0;
            if (clk_q)                lo_run <= '0;
            else if (lo_run < HALF_C) lo_run <= lo_run + CNT_W'(1);
        end
    end

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q) |-> (hi_run == HALF_C));
    // R4
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> (lo_run >= HALF_C));
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q != $past(data_q)) |-> (!clk_q && !$past(clk_q)));
    // R7
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE) |-> (!clk_q && !data_q));

endmodule

// File: rtl/tw_seq_fsm.sv
module tw_seq_fsm
    import twseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tx_done_i,
    input  logic sh_idle,
    input  logic sh_done,
    output logic go,
    output cmd_t cmd_sel,
    output logic busy_o
);

    seq_state_t state, nxt;
    logic       start_pend, done_pend, launched;
    logic       in_cmd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_BOOT_RST;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_BOOT_RST:  if (sh_done)                 nxt = SQ_BOOT_SOFT;
            SQ_BOOT_SOFT: if (sh_done)                 nxt = SQ_IDLE;
            SQ_IDLE:      if (start_i || start_pend)   nxt = SQ_PRE_RST;
            SQ_PRE_RST:   if (sh_done)                 nxt = SQ_PRE_OFF;
            SQ_PRE_OFF:   if (sh_done)                 nxt = SQ_TX_WAIT;
            SQ_TX_WAIT:   if (tx_done_i || done_pend)  nxt = SQ_POST_RST;
            SQ_POST_RST:  if (sh_done)                 nxt = SQ_POST_SOFT;
            SQ_POST_SOFT: if (sh_done)                 nxt = SQ_IDLE;
            default:                                   nxt = SQ_BOOT_RST;
        endcase
    end

    // held requests and command launch flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            done_pend  <= 1'b0;
            launched   <= 1'b0;
        end else begin
            if (state == SQ_IDLE) start_pend <= 1'b0;
            else if (start_i)     start_pend <= 1'b1;

            if ((state == SQ_PRE_RST || state == SQ_PRE_OFF) && tx_done_i)
                done_pend <= 1'b1;
            else if (state == SQ_TX_WAIT)
                done_pend <= 1'b0;

            if (sh_done) launched <= 1'b0;
            else if (go) launched <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_cmd  = (state != SQ_IDLE) && (state != SQ_TX_WAIT);
        busy_o  = in_cmd;
        go      = in_cmd && sh_idle && !launched;
        unique case (state)
            SQ_BOOT_SOFT, SQ_POST_SOFT: cmd_sel = CMD_SOFT_RST;
            SQ_PRE_OFF:                 cmd_sel = CMD_LINK_OFF;
            default:                    cmd_sel = CMD_LINK_RST;
        endcase
    end

    // R2
    off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PRE_OFF && $past(state) != SQ_PRE_OFF) |-> ($past(state) == SQ_PRE_RST));
    // R3
    soft_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_POST_SOFT && $past(state) != SQ_POST_SOFT) |-> ($past(state) == SQ_POST_RST));
    // R8
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_idle |-> busy_o);
    // R9
    held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && start_pend) |=> (state == SQ_PRE_RST));
    // R10
    held_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TX_WAIT && done_pend) |=> (state == SQ_POST_RST));

endmodule

// File: rtl/tx_cmd_sequencer.sv
module tx_cmd_sequencer
    import twseq_pkg::*;
#(
    parameter int               CLK_NS       = 4,
    parameter int               HALF_DIV     = 125,
    parameter int               HOLD_CYC     = 50,
    parameter int               MAX_LEN      = 16,
    parameter int               LINK_RST_LEN = 8,
    parameter logic [MAX_LEN-1:0] LINK_RST_PAT = 16'h008D,
    parameter int               SOFT_RST_LEN = 8,
    parameter logic [MAX_LEN-1:0] SOFT_RST_PAT = 16'h005B,
    parameter int               LINK_OFF_LEN = 8,
    parameter logic [MAX_LEN-1:0] LINK_OFF_PAT = 16'h0037
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tx_done_i,
    output logic tw_clk_o,
    output logic tw_data_o,
    output logic busy_o
);

    localparam int LEN_W = $clog2(MAX_LEN + 1);

    // elaboration-time timing checks
    if (HALF_DIV * CLK_NS < 500) begin : g_bad_min_phase
        $error("link clock phase shorter than 500 ns");
    end
    if (HALF_DIV * CLK_NS > 50000) begin : g_bad_max_period
        $error("link clock slower than 10 kHz");
    end
    if (HOLD_CYC * CLK_NS < 200 || HOLD_CYC >= HALF_DIV) begin : g_bad_hold
        $error("data hold offset out of range");
    end
    if (2 * HALF_DIV * CLK_NS + 4 * CLK_NS > 15000) begin : g_bad_first_edge
        $error("first falling edge later than 15 us");
    end
    if (LINK_RST_LEN < 1 || LINK_RST_LEN > MAX_LEN ||
        SOFT_RST_LEN < 1 || SOFT_RST_LEN > MAX_LEN ||
        LINK_OFF_LEN < 1 || LINK_OFF_LEN > MAX_LEN) begin : g_bad_len
        $error("command length out of range");
    end

    logic               go, sh_idle, sh_done;
    cmd_t               cmd_sel;
    logic [MAX_LEN-1:0] pat;
    logic [LEN_W-1:0]   len;

    always_comb begin
        unique case (cmd_sel)
            CMD_SOFT_RST: begin pat = SOFT_RST_PAT; len = LEN_W'(SOFT_RST_LEN); end
            CMD_LINK_OFF: begin pat = LINK_OFF_PAT; len = LEN_W'(LINK_OFF_LEN); end
            default:      begin pat = LINK_RST_PAT; len = LEN_W'(LINK_RST_LEN); end
        endcase
    end

    tw_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tx_done_i (tx_done_i),
        .sh_idle   (sh_idle),
        .sh_done   (sh_done),
        .go        (go),
        .cmd_sel   (cmd_sel),
        .busy_o    (busy_o)
    );

    tw_bit_shifter #(
        .HALF_DIV (HALF_DIV),
        .HOLD_CYC (HOLD_CYC),
        .MAX_LEN  (MAX_LEN)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .pat     (pat),
        .len     (len),
        .sclk    (tw_clk_o),
        .sdata   (tw_data_o),
        .sh_idle (sh_idle),
        .sh_done (sh_done)
    );

endmodule

// File: tb/sim_tx_cmd_sequencer.sv
module sim_tx_cmd_sequencer;

    localparam int HALF  = 125;
    localparam int HOLD  = 50;
    localparam int LIMIT = 3750;   // 15 us at 4 ns
    localparam logic [7:0] B_RST  = 8'h8D;
    localparam logic [7:0] B_SOFT = 8'h5B;
    localparam logic [7:0] B_OFF  = 8'h37;
    // {early done, delay in cycles}
    localparam logic [16:0] VEC [0:3] = '{
        {1'b0, 16'd300}, {1'b1, 16'd40}, {1'b0, 16'd1500}, {1'b1, 16'd2000}
    };

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, tx_done_i = 1'b0;
    logic tw_clk, tw_data, busy;

    always #2 clk = ~clk;

    tx_cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_done_i(tx_done_i),
        .tw_clk_o(tw_clk), .tw_data_o(tw_data), .busy_o(busy)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] cap [0:127];
    int cap_n = 0, bits = 0, edges = 0, viol4 = 0, viol5 = 0;
    int t_rise = 0, t_fall = 0, t_dchg = 0, t_brise = 0;
    logic [7:0] sh = 8'h00;
    bit first_pend = 1'b0;
    logic p_clk = 1'b0, p_data = 1'b0, p_busy = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // link monitor, sampling away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            t_brise    = cyc;
            first_pend = 1'b1;
        end else begin
            if (p_clk && !tw_clk) begin
                edges++;
                if (cyc - t_rise != HALF) viol4++;
                if (cyc - t_dchg < HALF)  viol5++;
                sh = {sh[6:0], tw_data};
                bits++;
                if (bits == 8) begin
                    cap[cap_n] = sh;
                    cap_n++;
                    bits = 0;
                end
                if (first_pend) begin
                    chk((cyc - t_brise) >= 5 && (cyc - t_brise) <= LIMIT,
                        "R6 first falling edge delay", cyc - t_brise, LIMIT);
                    first_pend = 1'b0;
                end
                t_fall = cyc;
            end
            if (!p_clk && tw_clk) begin
                if (cyc - t_fall < HALF) viol4++;
                t_rise = cyc;
            end
            if (tw_data != p_data) begin
                if (tw_clk || p_clk)     viol5++;
                if (cyc - t_fall < HOLD) viol5++;
                t_dchg = cyc;
            end
            if (!p_busy && busy) begin
                t_brise    = cyc;
                first_pend = 1'b1;
            end
            if (p_busy && !busy)
                chk(!tw_data && !tw_clk && (cyc - t_rise) <= LIMIT,
                    "R7 data released after last rise", cyc - t_rise, LIMIT);
        end
        p_clk  = tw_clk;
        p_data = tw_data;
        p_busy = busy;
    end

    task automatic wait_caps(input int n);
        for (int t = 0; t < 40000 && cap_n < n; t++) @(negedge clk);
    endtask

    task automatic wait_free();
        for (int t = 0; t < 40000 && busy; t++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
    endtask

    task automatic chk_pair(input int base, input logic [7:0] b0, input logic [7:0] b1,
                            input string tag);
        chk(cap_n > base + 1 && cap[base] == b0, tag, int'(cap[base]), int'(b0));
        chk(cap_n > base + 1 && cap[base+1] == b1, tag, int'(cap[base+1]), int'(b1));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cap_n, 0);
        summary();
    end

    initial begin
        int base, e0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(tw_clk == 1'b0, "R1 clk in reset", tw_clk, 0);
        chk(tw_data == 1'b0, "R1 data in reset", tw_data, 0);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(busy == 1'b1, "R8 busy during boot", busy, 1);
        pulse_start();                       // R9 start held during boot
        wait_caps(4);
        wait_free();
        chk_pair(0, B_RST, B_SOFT, "R1 boot order");
        chk_pair(2, B_RST, B_OFF, "R9 held start runs pre sequence");
        pulse_done();
        wait_caps(6);
        wait_free();
        chk_pair(4, B_RST, B_SOFT, "R3 post order");

        // table of transmissions
        for (int i = 0; i < 4; i++) begin
            base = cap_n;
            pulse_start();
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R8 busy after start", busy, 1);
            if (VEC[i][16]) begin
                repeat (int'(VEC[i][15:0])) @(negedge clk);
                pulse_done();                // R10 early done
                chk(busy == 1'b1, "R10 early done inside pre", busy, 1);
                wait_caps(base + 4);
                wait_free();
                chk_pair(base + 2, B_RST, B_SOFT, "R10 latched done runs post");
            end else begin
                wait_caps(base + 2);
                wait_free();
                e0 = edges;
                repeat (int'(VEC[i][15:0])) @(negedge clk);
                chk(edges == e0 && !busy, "R8 quiet while transmitting", edges - e0, 0);
                pulse_done();
                wait_caps(base + 4);
                wait_free();
                chk_pair(base + 2, B_RST, B_SOFT, "R3 post order");
            end
            chk_pair(base, B_RST, B_OFF, "R2 pre order");
        end

        // R9 start during the transmission window
        base = cap_n;
        pulse_start();
        wait_caps(base + 2);
        wait_free();
        e0 = edges;
        pulse_start();
        repeat (500) @(negedge clk);
        chk(edges == e0 && !busy, "R9 start held in tx window", edges - e0, 0);
        pulse_done();
        wait_caps(base + 6);
        wait_free();
        chk_pair(base + 2, B_RST, B_SOFT, "R3 post before held start");
        chk_pair(base + 4, B_RST, B_OFF, "R9 held start after post");
        pulse_done();
        wait_caps(base + 8);
        wait_free();

        // R10 done in idle is dropped
        e0 = edges;
        pulse_done();
        repeat (2000) @(negedge clk);
        chk(edges == e0 && !busy, "R10 done in idle ignored", edges - e0, 0);
        base = cap_n;
        pulse_start();
        wait_caps(base + 2);
        wait_free();
        e0 = edges;
        repeat (1000) @(negedge clk);
        chk(edges == e0 && !busy, "R10 no stale done kept", edges - e0, 0);
        pulse_done();
        wait_caps(base + 4);
        wait_free();
        chk_pair(base + 2, B_RST, B_SOFT, "R3 post order");

        chk(viol4 == 0, "R4 clock phase lengths", viol4, 0);
        chk(viol5 == 0, "R5 data change timing", viol5, 0);
        summary();
    end

endmodule